// File: doc/BRIEF.md
# Debug Interrupt Request Logic

This block sits between a processor core's debug front end and its exception logic. Two sources can ask for a debug interrupt. One is an active-low breakpoint pin that arrives with no timing relation to the core clock. The other is a single-cycle "background" strobe from the serial debug interface. A mode bit decides what these sources do. When the bit is clear, they keep their ordinary function and drive a halt request to the core. When the bit is set, they become debug interrupt sources. In that mode a falling edge on the pin, or a background strobe, raises a request.

A raised request is held pending. It is handed to the core only at the next instruction sample point, which the core marks with a one-cycle strobe once per instruction. When the request is taken, the block gives a one-cycle interrupt-taken pulse and enters an in-service state. It leaves that state when the core signals that the service routine is complete. Debug interrupts never nest. Any request that arrives while one is in service is discarded, not stored.

The breakpoint pin passes through a synchroniser of `SYNC_STAGES` flops before edge detection. A pin that stays low therefore counts as one event.

Top module: `dbg_irq_ctl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `irq_taken` and `halt_req` are 0, nothing is pending or in service, and every synchroniser flop and the edge history hold 1. A pin that is low when reset is released therefore counts as one falling edge once it has passed the synchroniser.
- R2: With `irq_mode` = 0, `halt_req` is registered. It is 1 in the cycle after an edge where either the synchronised pin was 0 or `bg_cmd` was 1, and 0 otherwise. A pin change reaches `halt_req` `SYNC_STAGES`+1 edges after it is sampled. No interrupt request is raised in this mode.
- R3: With `irq_mode` = 1, each high-to-low transition of the synchronised pin raises exactly one request. A pin held low raises nothing further, a rising edge raises nothing, and `halt_req` stays 0.
- R4: With `irq_mode` = 1, a cycle with `bg_cmd` = 1 raises a request.
- R5: A raised request becomes pending at the next clock edge. It stays pending through any number of cycles with `insn_sample` = 0. A change of `irq_mode` does not clear it.
- R6: `irq_taken` is 1 exactly in a cycle where `insn_sample` = 1 and a request is pending. That edge clears the pending flag and enters the in-service state.
- R7: While in service, `irq_taken` stays 0 and every request raised is dropped. Requests raised before `svc_done` are not remembered, and one raised in the same cycle as `svc_done` is dropped as well.
- R8: `svc_done` = 1 while in service leaves the service state at that edge. `svc_done` outside service has no effect.
- R9: A request raised in the same cycle that a pending request is taken is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_pin_n | input | 1 | Asynchronous breakpoint pin, active low |
| bg_cmd | input | 1 | One-cycle background command strobe from the debug interface |
| irq_mode | input | 1 | 0: halt behaviour, 1: edge-triggered debug interrupt |
| insn_sample | input | 1 | Per-instruction sample-point strobe |
| svc_done | input | 1 | Debug service routine complete |
| irq_taken | output | 1 | One-cycle pulse: the debug interrupt is taken now |
| halt_req | output | 1 | Halt request to the core (halt mode only) |

## Verification
Each wrong internal state shows at the ports within one sample point. A pending flag that is lost or stuck shows as a missing or extra `irq_taken` at the next `insn_sample`. A service flag that fails to set or clear lets a nested pulse through, or blocks every later request. A synchroniser or edge history of the wrong length, or a wrong reset value, shifts `halt_req` by whole cycles. It also adds or removes a request after reset or while the pin is held low. The bench keeps its own model and compares both outputs on every clock. Faults therefore surface in the cycle they first matter.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

  // Idle level of the active-low breakpoint pin.
  localparam logic PIN_IDLE = 1'b1;

  typedef struct packed {
    logic pend;
    logic busy;
  } dbg_req_state_t;

  // High-to-low transition between the previous and current synced level.
  function automatic logic f_fall(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction

  // A request is raised only in interrupt mode.
  function automatic logic f_raise(input logic mode, input logic fall, input logic cmd);
    return mode & (fall | cmd);
  endfunction

  // Next pending/in-service state.
  function automatic dbg_req_state_t f_req_next(input dbg_req_state_t cur,
                                                input logic raise,
                                                input logic sample,
                                                input logic done);
    dbg_req_state_t nxt;
    logic take;
    take     = sample & cur.pend;
    nxt.pend = (cur.pend & ~take) | (raise & ~cur.busy & ~take);
    nxt.busy = take | (cur.busy & ~done);
    return nxt;
  endfunction

  // Halt mode: level of pin or command strobe.
  function automatic logic f_halt_next(input logic mode, input logic pin_lvl, input logic cmd);
    return ~mode & (~pin_lvl | cmd);
  endfunction

endpackage

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic pin_sync
);
  import dbg_irq_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= PIN_IDLE;
          else     chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= PIN_IDLE;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[LAST];

  // R1: the synchronised level comes out of reset at idle-high
  a_r1_sync_idle: assert property (@(posedge clk) $past(rst) |-> pin_sync == PIN_IDLE);

endmodule

// File: rtl/dbg_edge_det.sv
module dbg_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  import dbg_irq_pkg::*;

  logic prev_lvl;

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= PIN_IDLE;
    else     prev_lvl <= lvl;
  end

  assign fall = f_fall(prev_lvl, lvl);

  // R3: a low level held on the pin yields a single event
  a_r3_single_fall: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);

endmodule

// File: rtl/dbg_req_hold.sv
module dbg_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic sample,
  input  logic done,
  output logic taken,
  output logic pending,
  output logic in_svc
);
  import dbg_irq_pkg::*;

  dbg_req_state_t st_q;
  dbg_req_state_t st_d;

  assign st_d = f_req_next(st_q, raise, sample, done);

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign taken   = sample & st_q.pend;
  assign pending = st_q.pend;
  assign in_svc  = st_q.busy;

  // R5: pending survives cycles with no sample point
  a_r5_pend_hold: assert property (@(posedge clk) disable iff (rst)
    pending && !sample |=> pending);
  // R6: taking the request clears pending and enters service
  a_r6_take_enters_svc: assert property (@(posedge clk) disable iff (rst)
    taken |=> !pending && in_svc);
  // R7: a request raised in service is discarded
  a_r7_drop_in_svc: assert property (@(posedge clk) disable iff (rst)
    in_svc && raise |=> !pending);
  // R8: completion leaves the service state
  a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
    in_svc && done |=> !in_svc);
  // R9: a request coinciding with a take is discarded
  a_r9_drop_on_take: assert property (@(posedge clk) disable iff (rst)
    taken && raise |=> !pending);

endmodule

// File: rtl/dbg_halt_gen.sv
module dbg_halt_gen (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic pin_lvl,
  input  logic cmd,
  output logic halt
);
  import dbg_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) halt <= 1'b0;
    else     halt <= f_halt_next(mode, pin_lvl, cmd);
  end

  // R2/R3: a halt request only follows a cycle in halt mode
  a_r2_halt_mode_only: assert property (@(posedge clk) disable iff (rst)
    halt |-> $past(!mode));

endmodule

// File: rtl/dbg_irq_ctl.sv
module dbg_irq_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic brk_pin_n,
  input  logic bg_cmd,
  input  logic irq_mode,
  input  logic insn_sample,
  input  logic svc_done,
  output logic irq_taken,
  output logic halt_req
);
  import dbg_irq_pkg::*;

  // Named internal events
  logic pin_lvl;
  logic pin_fall;
  logic req_raise;
  logic req_pending;
  logic req_in_svc;

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (brk_pin_n),
    .pin_sync  (pin_lvl)
  );

  dbg_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_lvl),
    .fall (pin_fall)
  );

  assign req_raise = f_raise(irq_mode, pin_fall, bg_cmd);

  dbg_req_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .raise   (req_raise),
    .sample  (insn_sample),
    .done    (svc_done),
    .taken   (irq_taken),
    .pending (req_pending),
    .in_svc  (req_in_svc)
  );

  dbg_halt_gen u_halt (
    .clk     (clk),
    .rst     (rst),
    .mode    (irq_mode),
    .pin_lvl (pin_lvl),
    .cmd     (bg_cmd),
    .halt    (halt_req)
  );

  // R7: no nesting at the port
  a_r7_no_nest: assert property (@(posedge clk) disable iff (rst)
    req_in_svc |-> !irq_taken);
  // R6: the taken pulse lasts one cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_taken |=> !irq_taken);
  // R6: pending and service are never both set
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(req_pending && req_in_svc));

endmodule

// File: tb/tb_dbg_irq_ctl.sv
module tb_dbg_irq_ctl;
  localparam int  SYNC   = 2;
  localparam time PERIOD = 10ns;
  localparam int  WDOG   = 200000;

  logic clk = 1'b0;
  logic rst, brk_pin_n, bg_cmd, irq_mode, insn_sample, svc_done;
  logic irq_taken, halt_req;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  always #(PERIOD/2) clk = ~clk;

  dbg_irq_ctl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .brk_pin_n(brk_pin_n), .bg_cmd(bg_cmd),
    .irq_mode(irq_mode), .insn_sample(insn_sample), .svc_done(svc_done),
    .irq_taken(irq_taken), .halt_req(halt_req)
  );

  // Behavioural reference model
  bit m_q[$];
  bit m_prev, m_pend, m_busy, m_halt, m_cur, m_fall, m_raise, m_take;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
      m_prev = 1; m_pend = 0; m_busy = 0; m_halt = 0;
    end else begin
      m_cur   = m_q[0];
      m_fall  = m_prev && !m_cur;
      m_raise = irq_mode && (m_fall || bg_cmd);
      m_take  = insn_sample && m_pend;
      m_halt  = !irq_mode && (!m_cur || bg_cmd);
      if (m_take) begin m_pend = 0; m_busy = 1; end
      else if (m_busy) begin if (svc_done) m_busy = 0; end
      else if (m_raise) m_pend = 1;
      m_prev = m_cur;
      void'(m_q.pop_front());
      m_q.push_back(brk_pin_n);
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // One clock; compare both outputs mid-cycle against the model.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(irq_taken, insn_sample && m_pend, "irq_taken");
    check(halt_req, m_halt, "halt_req");
  endtask

  task automatic idle();
    bg_cmd = 0; insn_sample = 0; svc_done = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Directed check of an expected pulse, from the requirement alone.
  task automatic expect_taken(input logic exp);
    insn_sample = 1;
    #1;
    check(irq_taken, exp, "directed irq_taken");
    tick();
    insn_sample = 0;
  endtask

  initial begin
    rst = 1; brk_pin_n = 1; irq_mode = 0; idle();
    cur_req = "R1";
    ticks(3);
    rst = 0;
    check(irq_taken, 1'b0, "reset irq_taken");
    check(halt_req, 1'b0, "reset halt_req");
    ticks(4);

    // R2: halt mode follows pin level and command strobe
    cur_req = "R2";
    brk_pin_n = 0; tick(); tick();
    check(halt_req, 1'b0, "halt before sync delay");
    tick();
    check(halt_req, 1'b1, "halt after sync delay");
    ticks(3);
    brk_pin_n = 1; ticks(4);
    bg_cmd = 1; tick(); bg_cmd = 0;
    check(halt_req, 1'b1, "halt from command");
    tick();
    check(halt_req, 1'b0, "halt released");
    expect_taken(1'b0);

    // R3/R5/R6: edge-triggered request held until the sample point
    cur_req = "R3";
    irq_mode = 1;
    brk_pin_n = 0; ticks(12);
    check(halt_req, 1'b0, "no halt in irq mode");
    cur_req = "R5";
    irq_mode = 0; ticks(2); irq_mode = 1;
    cur_req = "R6";
    expect_taken(1'b1);
    cur_req = "R8";
    svc_done = 1; tick(); svc_done = 0;
    cur_req = "R3";
    ticks(3);
    expect_taken(1'b0);
    brk_pin_n = 1; ticks(5);
    expect_taken(1'b0);

    // R4: command strobe in interrupt mode
    cur_req = "R4";
    bg_cmd = 1; tick(); bg_cmd = 0;
    expect_taken(1'b1);

    // R7: requests during service are dropped
    cur_req = "R7";
    bg_cmd = 1; tick(); bg_cmd = 0;
    brk_pin_n = 0; ticks(4); brk_pin_n = 1; ticks(2);
    expect_taken(1'b0);
    bg_cmd = 1; svc_done = 1; tick(); idle();
    expect_taken(1'b0);

    // R8: done outside service has no effect; a new request is then taken
    cur_req = "R8";
    svc_done = 1; tick(); svc_done = 0;
    bg_cmd = 1; tick(); bg_cmd = 0;
    expect_taken(1'b1);
    svc_done = 1; tick(); svc_done = 0;

    // R9: request raised on the take cycle is dropped
    cur_req = "R9";
    bg_cmd = 1; tick(); bg_cmd = 0;
    bg_cmd = 1; expect_taken(1'b1); bg_cmd = 0;
    svc_done = 1; tick(); svc_done = 0;
    expect_taken(1'b0);

    // R1: pin low across reset yields one event after release
    cur_req = "R1";
    rst = 1; brk_pin_n = 0; ticks(2); rst = 0;
    ticks(SYNC + 2);
    expect_taken(1'b1);
    svc_done = 1; tick(); svc_done = 0;
    brk_pin_n = 1; ticks(3);

    // Mixed stimulus against the model
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) brk_pin_n = ~brk_pin_n;
      bg_cmd      = ($urandom_range(15) == 0);
      insn_sample = ($urandom_range(3) == 0);
      svc_done    = ($urandom_range(9) == 0);
      if ($urandom_range(199) == 0) irq_mode = ~irq_mode;
      rst         = ($urandom_range(499) == 0);
      tick();
    end
    rst = 0; idle(); ticks(2);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule